// File: doc/BRIEF.md
# Four-Channel Serial Output Formatter

This block takes four complex channel samples and sends them out on a serial link. Each sample is a 16-bit in-phase (I) word and a 16-bit quadrature (Q) word. The link has a serial clock, a frame strobe and four data lines. A one-cycle `newSample` pulse latches all four channels at once. The block then runs one frame that shifts the latched words out. Each word is led by a strobe bit and its data follows MSB first.

A two-bit routing control picks how the channels reach the data lines:
- every channel on its own line;
- two channels in turn on each of two lines;
- all four channels in turn on one line.

I and Q of a channel always share a line. In split framing, I and Q each get their own strobe. In packed framing, the pair goes out as one 32-bit word behind a single strobe.

Further controls:
- The strobe level can be inverted.
- The serial clock can be inverted, which moves the launch to its falling edge.
- A `ready` pulse flags the first word of each frame.
- The serial pins are meant to sit behind tri-state pad buffers. The block drives a pad output enable for them and forces quiet levels on those pins while it is disabled.

The serial clock runs at half the system clock. One serial bit lasts two system clock cycles.

Top module: `tdm_serial_formatter`

## Requirements
- R1: After reset, `ready` and all `serData` lines are 0 and the strobe is at its inactive level. No frame starts until a `newSample` pulse arrives.
- R2: A `newSample` pulse that arrives while no frame is running latches all four channels. The first bit of the frame is launched within two serial bits. `ready` is high for exactly the first bit of the frame, which is the strobe bit of the first word.
- R3: Routing 0: channel c (c = 0..3, taken from `chanI/chanQ[16c +: 16]`) goes out on `serData[c]`. All four lines run in parallel.
- R4: Routing 1: `serData[0]` carries channel 0 then channel 1. `serData[1]` carries channel 2 then channel 3.
- R5: Routing 2 and routing 3 both send channels 0, 1, 2 and 3 in that order on `serData[0]`.
- R6: Split framing (`packedMode`=0): for each channel, a strobe bit is followed by 16 bits of I, MSB first. Then a second strobe bit is followed by 16 bits of Q, MSB first.
- R7: Packed framing (`packedMode`=1): one strobe bit is followed by 32 bits, I[15] first down to Q[0].
- R8: Words on one line follow each other with no idle bits. Each strobe sits in the bit right after the previous word's last data bit. During data bits the strobe is inactive, and during strobe bits the data lines are 0.
- R9: Data, strobe and `ready` change only at the launch edge of `serClk`. That edge is the rising edge when `clkInvert`=0 and the falling edge when `clkInvert`=1. They hold through the other half of the bit.
- R10: The active strobe level is high when `strobeInvert`=0 and low when `strobeInvert`=1.
- R11: `padOe` follows `outEnable`. While `outEnable`=0: `serData` is 0, `serClk` is 0 and `frameStrobe` sits at its inactive level. `ready` still marks frames.
- R12: A `newSample` pulse during a running frame is ignored. The remaining words keep the values latched at frame start, and no extra frame follows.
- R13: Data lines that carry no channel in the current routing stay at 0: lines 2 and 3 in routing 1, and lines 1 to 3 in routings 2 and 3.
- R14: Once the last bit of a frame is out, the lines go idle: strobe inactive, data 0 and `ready` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| newSample | input | 1 | One-cycle pulse that latches all channels and starts a frame |
| chanI | input | 64 | I words; channel c at bits [16c +: 16] |
| chanQ | input | 64 | Q words; channel c at bits [16c +: 16] |
| muxMode | input | 2 | Line routing: 0 four lines, 1 two lines, 2 or 3 one line |
| packedMode | input | 1 | 1 sends I/Q as one 32-bit word |
| strobeInvert | input | 1 | 1 makes the strobe active low |
| clkInvert | input | 1 | 1 launches data on the falling edge of `serClk` |
| outEnable | input | 1 | Enables driving of the serial pins |
| serClk | output | 1 | Serial bit clock |
| frameStrobe | output | 1 | Word strobe |
| serData | output | 4 | Serial data lines |
| ready | output | 1 | Marks the first word of a frame |
| padOe | output | 1 | Output enable for the serial pad buffers |

## Verification
The bench sweeps every combination of routing, framing, strobe polarity and clock polarity. It uses a different channel pattern for each run and compares every bit of every frame with a bit stream built arithmetically from the requirements.

Distinct I and Q values per channel catch these errors:
- a wrong channel order on a shared line;
- I and Q sent in the wrong order;
- an LSB-first shift.

The two framings differ in strobe count and word length, so a misplaced or extra strobe bit shows up. Sampling both halves of every bit with both clock polarities catches a launch on the wrong edge. Further runs check:
- routing value 3;
- a `newSample` pulse in the middle of a long single-line frame, with altered inputs;
- a disabled output stage.

// File: rtl/tdmfmt_pkg.sv
`timescale 1ns/1ps
package tdmfmt_pkg;
  localparam int WORD_W   = 16;
  localparam int NUM_CH   = 4;
  localparam int NUM_PINS = 4;
  localparam int PAIR_W   = 2 * WORD_W;
  localparam int IDX_W    = $clog2(PAIR_W);
  localparam int CHSEL_W  = $clog2(NUM_CH);

  typedef enum logic [1:0] {
    MUX_QUAD       = 2'd0,
    MUX_DUAL       = 2'd1,
    MUX_SINGLE     = 2'd2,
    MUX_SINGLE_ALT = 2'd3
  } muxSel_e;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic                launch;     // this clock edge is a serial launch edge
    logic                active;     // frame pending or running
    logic                capture;    // latch channel inputs now
    logic                emit;       // a frame bit is launched at this edge
    logic                strobeSlot; // current bit is a word strobe
    logic                firstSlot;  // current bit is the first of the frame
    muxSel_e             mode;       // routing latched for this frame
    logic [CHSEL_W-1:0]  chanSeq;    // channel position along a shared line
    logic [IDX_W-1:0]    bitIdx;     // bit of {I,Q} to put on the line
  } fmtCtl_t;
endpackage

// File: rtl/tdmfmt_ctrl.sv
`timescale 1ns/1ps
module tdmfmt_ctrl
  import tdmfmt_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       newSample,
  input  logic [1:0] muxMode,
  input  logic       packedMode,
  output logic       serPhase,
  output fmtCtl_t    ctl
);
  localparam int CNT_W  = $clog2(PAIR_W + 1);
  localparam int WIDX_W = $clog2(2 * NUM_CH);

  logic              phase;
  logic              run;
  logic              pending;
  logic              packedQ;
  muxSel_e           modeQ;
  logic [CNT_W-1:0]  bitCnt;
  logic [CNT_W-1:0]  lastBit;
  logic [CNT_W-1:0]  dataPos;
  logic [CNT_W-1:0]  topIdx;
  logic [WIDX_W-1:0] wordIdx;
  logic [WIDX_W-1:0] lastWord;
  logic              launch;
  logic              busy;
  logic              capture;
  logic              emit;
  logic              lastSlot;

  assign launch  = !phase;
  assign busy    = run | pending;
  assign capture = newSample & !busy;
  assign emit    = launch & busy;

  always_comb begin
    unique case (modeQ)
      MUX_QUAD: lastWord = WIDX_W'((NUM_CH / NUM_PINS) * (packedQ ? 1 : 2) - 1);
      MUX_DUAL: lastWord = WIDX_W'((NUM_CH / 2) * (packedQ ? 1 : 2) - 1);
      default:  lastWord = WIDX_W'(NUM_CH * (packedQ ? 1 : 2) - 1);
    endcase
    lastBit = packedQ ? CNT_W'(PAIR_W) : CNT_W'(WORD_W);
  end

  assign lastSlot = (bitCnt == lastBit) && (wordIdx == lastWord);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase   <= 1'b0;
      run     <= 1'b0;
      pending <= 1'b0;
      packedQ <= 1'b0;
      modeQ   <= MUX_QUAD;
      bitCnt  <= '0;
      wordIdx <= '0;
    end else begin
      phase <= !phase;
      if (capture) begin
        pending <= 1'b1;
        modeQ   <= muxSel_e'(muxMode);
        packedQ <= packedMode;
      end
      if (emit) begin
        pending <= 1'b0;
        if (lastSlot) begin
          run     <= 1'b0;
          bitCnt  <= '0;
          wordIdx <= '0;
        end else begin
          run <= 1'b1;
          if (bitCnt == lastBit) begin
            bitCnt  <= '0;
            wordIdx <= wordIdx + 1'b1;
          end else begin
            bitCnt <= bitCnt + 1'b1;
          end
        end
      end
    end
  end

  // Bit position inside {I,Q}: split framing restarts at the top of the Q half
  logic qHalf;
  assign qHalf   = !packedQ & wordIdx[0];
  assign dataPos = bitCnt - 1'b1;
  assign topIdx  = qHalf ? CNT_W'(WORD_W - 1) : CNT_W'(PAIR_W - 1);

  assign serPhase       = phase;
  assign ctl.launch     = launch;
  assign ctl.active     = busy;
  assign ctl.capture    = capture;
  assign ctl.emit       = emit;
  assign ctl.strobeSlot = (bitCnt == '0);
  assign ctl.firstSlot  = (bitCnt == '0) && (wordIdx == '0);
  assign ctl.mode       = modeQ;
  assign ctl.chanSeq    = packedQ ? wordIdx[CHSEL_W-1:0] : wordIdx[CHSEL_W:1];
  assign ctl.bitIdx     = IDX_W'(topIdx - dataPos);

  // R12: routing and framing stay fixed while a frame is pending or running
  a_r12_config_held: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> ($stable(modeQ) && $stable(packedQ)));

  // R8: inside a frame every launch edge emits a bit, so there is no gap
  a_r8_no_gap: assert property (@(posedge clk) disable iff (!rstN)
    (run && launch) |-> emit);
endmodule

// File: rtl/tdmfmt_datapath.sv
`timescale 1ns/1ps
module tdmfmt_datapath
  import tdmfmt_pkg::*;
(
  input  logic                       clk,
  input  logic                       rstN,
  input  fmtCtl_t                    ctl,
  input  logic [NUM_CH*WORD_W-1:0]   chanI,
  input  logic [NUM_CH*WORD_W-1:0]   chanQ,
  output logic                       strobeQ,
  output logic                       readyQ,
  output logic [NUM_PINS-1:0]        dataQ
);
  logic [NUM_CH-1:0][PAIR_W-1:0] held;
  logic [NUM_PINS-1:0]           pinBit;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      held <= '0;
    end else if (ctl.capture) begin
      for (int c = 0; c < NUM_CH; c++) begin
        held[c] <= {chanI[c*WORD_W +: WORD_W], chanQ[c*WORD_W +: WORD_W]};
      end
    end
  end

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic [CHSEL_W-1:0] srcCh;
    logic               live;
    always_comb begin
      unique case (ctl.mode)
        MUX_QUAD: begin
          srcCh = CHSEL_W'(p % NUM_CH);
          live  = 1'b1;
        end
        MUX_DUAL: begin
          srcCh = CHSEL_W'((p % 2) * 2) | CHSEL_W'(ctl.chanSeq[0]);
          live  = (p < 2);
        end
        default: begin
          srcCh = ctl.chanSeq;
          live  = (p == 0);
        end
      endcase
    end
    assign pinBit[p] = live & held[srcCh][ctl.bitIdx];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobeQ <= 1'b0;
      readyQ  <= 1'b0;
      dataQ   <= '0;
    end else if (ctl.launch) begin
      strobeQ <= ctl.emit & ctl.strobeSlot;
      readyQ  <= ctl.emit & ctl.firstSlot;
      dataQ   <= (ctl.emit && !ctl.strobeSlot) ? pinBit : '0;
    end
  end

  // R2: the frame marker only ever sits on a strobe bit
  a_r2_ready_on_strobe: assert property (@(posedge clk) disable iff (!rstN)
    readyQ |-> strobeQ);

  // R9: line values move only on launch edges
  a_r9_launch_only: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.launch |=> ($stable(dataQ) && $stable(strobeQ) && $stable(readyQ)));

  // R13: lines 2 and 3 carry nothing in two-line routing
  a_r13_dual_idle_pins: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.launch && ctl.mode == MUX_DUAL) |=> (dataQ[NUM_PINS-1:2] == '0));

  // R12: latched samples are frozen while a frame is pending or running
  a_r12_samples_held: assert property (@(posedge clk) disable iff (!rstN)
    ctl.active |=> $stable(held));

  // R6: a strobe lasts one bit, the next launched bit is data
  a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.launch && strobeQ) |-> !(ctl.emit && ctl.strobeSlot));
endmodule

// File: rtl/tdm_serial_formatter.sv
`timescale 1ns/1ps
module tdm_serial_formatter
  import tdmfmt_pkg::*;
(
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      newSample,
  input  logic [NUM_CH*WORD_W-1:0]  chanI,
  input  logic [NUM_CH*WORD_W-1:0]  chanQ,
  input  logic [1:0]                muxMode,
  input  logic                      packedMode,
  input  logic                      strobeInvert,
  input  logic                      clkInvert,
  input  logic                      outEnable,
  output logic                      serClk,
  output logic                      frameStrobe,
  output logic [NUM_PINS-1:0]       serData,
  output logic                      ready,
  output logic                      padOe
);
  fmtCtl_t             ctl;
  logic                serPhase;
  logic                strobeQ;
  logic                readyQ;
  logic [NUM_PINS-1:0] dataQ;

  tdmfmt_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .newSample  (newSample),
    .muxMode    (muxMode),
    .packedMode (packedMode),
    .serPhase   (serPhase),
    .ctl        (ctl)
  );

  tdmfmt_datapath dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .chanI   (chanI),
    .chanQ   (chanQ),
    .strobeQ (strobeQ),
    .readyQ  (readyQ),
    .dataQ   (dataQ)
  );

  // Phase is high in the half bit after a launch edge
  assign serClk      = outEnable & (serPhase ^ clkInvert);
  assign frameStrobe = outEnable ? (strobeQ ^ strobeInvert) : strobeInvert;
  assign serData     = outEnable ? dataQ : '0;
  assign ready       = readyQ;
  assign padOe       = outEnable;

  // R11: the pins stay quiet while the output stage is off
  a_r11_quiet_when_off: assert property (@(posedge clk) disable iff (!rstN)
    !padOe |-> (serData == '0 && !serClk));
endmodule

// File: tb/tdm_serial_formatter_tb_top.sv
`timescale 1ns/1ps
module tdm_serial_formatter_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic        newSample;
  logic [63:0] chanI;
  logic [63:0] chanQ;
  logic [1:0]  muxMode;
  logic        packedMode;
  logic        strobeInvert;
  logic        clkInvert;
  logic        outEnable;
  logic        serClk;
  logic        frameStrobe;
  logic [3:0]  serData;
  logic        ready;
  logic        padOe;

  int checks = 0;
  int errors = 0;
  logic [15:0] curI [4];
  logic [15:0] curQ [4];

  always #10 clk = ~clk;

  tdm_serial_formatter dut_i (
    .clk(clk), .rstN(rstN), .newSample(newSample), .chanI(chanI), .chanQ(chanQ),
    .muxMode(muxMode), .packedMode(packedMode), .strobeInvert(strobeInvert),
    .clkInvert(clkInvert), .outEnable(outEnable), .serClk(serClk),
    .frameStrobe(frameStrobe), .serData(serData), .ready(ready), .padOe(padOe)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int frameLen(input int mode, input bit pk);
    int cpp;
    cpp = (mode == 0) ? 1 : ((mode == 1) ? 2 : 4);
    return cpp * (pk ? 1 : 2) * (pk ? 33 : 17);
  endfunction

  // {ready, strobe active, data[3:0]} for frame bit s
  function automatic logic [5:0] expSlot(input int mode, input bit pk, input int s);
    logic [5:0]  r;
    logic [31:0] pair;
    int spw, wpc, w, b, k, ch, d;
    bit half;
    r    = '0;
    spw  = pk ? 33 : 17;
    wpc  = pk ? 1 : 2;
    w    = s / spw;
    b    = s % spw;
    k    = w / wpc;
    half = pk ? 1'b0 : bit'(w % 2);
    r[5] = (s == 0);
    r[4] = (b == 0);
    for (int p = 0; p < 4; p++) begin
      ch = -1;
      if (mode == 0) ch = p;
      else if (mode == 1 && p < 2) ch = 2 * p + k;
      else if (mode >= 2 && p == 0) ch = k;
      if (b != 0 && ch >= 0) begin
        d    = b - 1;
        pair = {curI[ch], curQ[ch]};
        if (pk) r[p] = pair[31 - d];
        else if (half) r[p] = curQ[ch][15 - d];
        else r[p] = curI[ch][15 - d];
      end
    end
    return r;
  endfunction

  task automatic loadSamples(input int seed);
    for (int c = 0; c < 4; c++) begin
      curI[c] = 16'(seed * 40503 + c * 9973) ^ 16'h5A3C;
      curQ[c] = 16'(seed * 2654 + c * 31337 + 12345);
      chanI[c*16 +: 16] = curI[c];
      chanQ[c*16 +: 16] = curQ[c];
    end
  endtask

  task automatic pulseNew();
    @(negedge clk) newSample = 1'b1;
    @(negedge clk) newSample = 1'b0;
  endtask

  task automatic runFrame(input int mode, input bit pk, input bit sInv,
                          input bit cInv, input int seed, input bit midUpd);
    int launches, len, strobes, unstable, words;
    bit found, badUnused, readySeen;
    logic [5:0] got, exp, half2;
    string tag;
    @(negedge clk);
    muxMode = 2'(mode); packedMode = pk; strobeInvert = sInv; clkInvert = cInv;
    loadSamples(seed);
    pulseNew();
    launches = 0; found = 0;
    for (int i = 0; i < 12 && !found; i++) begin
      if (serClk == !cInv) begin
        launches++;
        if (ready) found = 1;
      end
      if (!found) @(negedge clk);
    end
    check(found && launches <= 2, "R2", "bits until frame start", launches, 2);
    if (!found) return;
    tag = (mode == 0) ? "R3" : ((mode == 1) ? "R4" : "R5");
    tag = {tag, pk ? "/R7" : "/R6"};
    len = frameLen(mode, pk);
    strobes = 0; unstable = 0; badUnused = 0;
    for (int s = 0; s < len + 3; s++) begin
      got = {ready, frameStrobe ^ sInv, serData};
      if (s < len) begin
        exp = expSlot(mode, pk, s);
        check(got == exp, tag, $sformatf("frame bit %0d", s), got, exp);
        if (got[4]) strobes++;
        if (mode == 1 && got[3:2] != 0) badUnused = 1;
        if (mode >= 2 && got[3:1] != 0) badUnused = 1;
      end else begin
        check(got == 6'b0, "R14", $sformatf("idle bit %0d", s - len), got, 0);
      end
      if (midUpd && s == 10) begin
        newSample = 1'b1;
        chanI = ~chanI;
        chanQ = chanQ ^ 64'h3C3C_A5A5_0F0F_9696;
      end
      @(negedge clk);
      if (midUpd && s == 10) newSample = 1'b0;
      half2 = {ready, frameStrobe ^ sInv, serData};
      if (serClk != cInv || half2 != got) unstable++;
      @(negedge clk);
    end
    words = ((mode == 0) ? 1 : ((mode == 1) ? 2 : 4)) * (pk ? 1 : 2);
    check(unstable == 0, "R9", "values changed off the launch edge", unstable, 0);
    check(strobes == words, "R8", "strobes per frame", strobes, words);
    check(!badUnused, "R13", "unused line driven", badUnused, 0);
    check(frameStrobe == sInv, "R10", "idle strobe level", frameStrobe, sInv);
    if (midUpd) begin
      readySeen = 0;
      for (int i = 0; i < 80; i++) begin
        @(negedge clk);
        if (ready) readySeen = 1;
      end
      check(!readySeen, "R12", "extra frame after ignored pulse", readySeen, 0);
    end
  endtask

  initial begin
    #(200000 * 20);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    bit bad, badOe, badClk, readySeen;
    int seed;
    rstN = 1'b0; newSample = 1'b0; muxMode = 2'd0; packedMode = 1'b0;
    strobeInvert = 1'b0; clkInvert = 1'b0; outEnable = 1'b1;
    chanI = '0; chanQ = '0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (ready || serData != 0 || frameStrobe) bad = 1;
    end
    check(!bad, "R1", "quiet lines after reset", bad, 0);
    check(padOe == 1'b1, "R11", "pad enable follows enable input", padOe, 1);

    seed = 1;
    for (int m = 0; m < 3; m++)
      for (int p = 0; p < 2; p++)
        for (int si = 0; si < 2; si++)
          for (int ci = 0; ci < 2; ci++) begin
            runFrame(m, bit'(p), bit'(si), bit'(ci), seed, 1'b0);
            seed++;
          end

    // R5: routing value 3 behaves as single-line
    runFrame(3, 1'b0, 1'b0, 1'b1, seed, 1'b0);
    seed++;
    runFrame(3, 1'b1, 1'b1, 1'b0, seed, 1'b0);
    seed++;

    // R12: mid-frame pulse with changed inputs on a long frame
    runFrame(2, 1'b0, 1'b1, 1'b0, seed, 1'b1);
    seed++;

    // R11: output stage disabled during a frame
    @(negedge clk);
    outEnable = 1'b0; strobeInvert = 1'b1; muxMode = 2'd0; packedMode = 1'b0;
    loadSamples(seed);
    pulseNew();
    bad = 0; badOe = 0; badClk = 0; readySeen = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (serData != 0 || frameStrobe != 1'b1) bad = 1;
      if (padOe) badOe = 1;
      if (serClk) badClk = 1;
      if (ready) readySeen = 1;
    end
    check(!bad, "R11", "data or strobe active while disabled", bad, 0);
    check(!badOe, "R11", "pad enable while disabled", badOe, 0);
    check(!badClk, "R11", "serial clock while disabled", badClk, 0);
    check(readySeen, "R11", "frame marker while disabled", readySeen, 1);
    outEnable = 1'b1;
    seed++;
    runFrame(1, 1'b1, 1'b0, 1'b0, seed, 1'b0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule